// File: doc/BRIEF.md
# Scaled Index Address Generator

This block forms the effective address for a family of indexed load operations in which the index operand is scaled before it is added. The index value is shifted left by the shift field plus one, so the scale is always at least two. The shifted index is added to a base to give the address. The block also decides whether the load writes its computed address back into the base register. It also reports when the combination of operation, update request and register numbers is not a legal form.

The load unit places the block behind instruction decode. Each cycle it presents the decoded load kind, an update-form bit, the base and destination register field numbers, the two operand values and the 2-bit shift field, qualified by `in_valid`. The outputs are the address, a base-register write request with its register number, and an invalid-form flag. These results go through one register stage by default (`REG_OUT=1`). With `REG_OUT=0` they are produced in the same cycle.

Load kind codes on `ld_kind` are as follows:
- 0: byte, zero-extended
- 1: halfword, zero-extended
- 2: halfword, sign-extended
- 3: word, zero-extended
- 4: word, sign-extended
- 5: doubleword
- 6: halfword, byte-swapped
- 7: word, byte-swapped
- 8: doubleword, byte-swapped
- 9 to 15: unassigned

Top module: `sia_agen`

## Requirements
- R1: `ea` equals base + `rb_val` * 2^(`sh_amt`+1), modulo 2^64. Index bits shifted past bit 63 are lost, and `sh_amt` values 0..3 give scales of 2, 4, 8 and 16.
- R2: In a non-update form (`upd_form`=0) with `ra_sel`=0, the base is zero whatever `ra_val` holds. With any other `ra_sel`, the base is `ra_val`.
- R3: In an update form, the base is always `ra_val`. A legal update raises `wb_en` with `wb_reg` = `ra_sel`, and `ea` is the value to be written.
- R4: An update form with `ra_sel`=0 raises `bad_form`, for every load kind.
- R5: An update form of kinds 2, 3, 4 or 5 with `ra_sel` equal to `rt_sel` raises `bad_form`.
- R6: An update form of kinds 0 or 1 with `ra_sel` equal to `rt_sel` (nonzero) is legal: `bad_form` stays low and `wb_en` is raised.
- R7: Kinds 6, 7 and 8 have no update form. Requesting one raises `bad_form`. Unassigned kinds 9..15 always raise `bad_form`. None of these ever raises `wb_en`.
- R8: `wb_en` is never high together with `bad_form`. A non-update form never raises `wb_en`. `wb_reg` reads 0 whenever `wb_en` is low.
- R9: With `REG_OUT`=1, the results of an input presented at one rising edge appear on the outputs after that edge, with `out_valid` high. Reset clears every output to 0.
- R10: When `in_valid` is low, the following cycle shows `out_valid`, `wb_en` and `bad_form` low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output stage |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| ld_kind | input | 4 | Load kind code (see table above) |
| upd_form | input | 1 | Operation is the update form |
| ra_sel | input | REGW | Base register field number |
| rt_sel | input | REGW | Destination register field number |
| ra_val | input | XLEN | Contents of the base register |
| rb_val | input | XLEN | Contents of the index register |
| sh_amt | input | SHW | Shift field; the index is shifted by sh_amt+1 |
| out_valid | output | 1 | Result outputs are meaningful |
| ea | output | XLEN | Effective address |
| wb_en | output | 1 | Write `ea` back into register `wb_reg` |
| wb_reg | output | REGW | Register number for the write-back |
| bad_form | output | 1 | Illegal operation form |

## Verification
The assertions take for granted that `ld_kind`, `upd_form` and the register fields are already settled values when `in_valid` is high. They also assume `rst_n` is held low long enough to clear the output register before the first valid operation. The stimulus changes inputs only at the falling edge and keeps `in_valid` low during reset. It walks every load kind against both update settings, with `ra_sel` at zero, equal to `rt_sel`, and distinct. It also covers all four shift values and operands chosen to carry out of bit 63.

// File: rtl/sia_pkg.sv
package sia_pkg;
  localparam int unsigned KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_BYTE_Z  = 4'd0,
    K_HALF_Z  = 4'd1,
    K_HALF_S  = 4'd2,
    K_WORD_Z  = 4'd3,
    K_WORD_S  = 4'd4,
    K_DBL     = 4'd5,
    K_HALF_SW = 4'd6,
    K_WORD_SW = 4'd7,
    K_DBL_SW  = 4'd8
  } ld_kind_e;

  localparam logic [KIND_W-1:0] KIND_LAST = 4'd8;

  // Scaled address sum: shift is always field + 1, addition wraps.
  function automatic logic [63:0] scaled_sum(input logic [63:0] base,
                                             input logic [63:0] idx,
                                             input int unsigned sh);
    return base + (idx << (sh + 1));
  endfunction

  // Update forms that also reject a base equal to the destination.
  function automatic logic rejects_alias(input logic [KIND_W-1:0] k);
    return (k == K_HALF_S) || (k == K_WORD_S) || (k == K_WORD_Z) || (k == K_DBL);
  endfunction

  // Kinds with no update form at all.
  function automatic logic no_update_kind(input logic [KIND_W-1:0] k);
    return (k >= K_HALF_SW);
  endfunction
endpackage

// File: rtl/sia_ea_calc.sv
module sia_ea_calc #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned REGW = 5,
  parameter int unsigned SHW  = 2
) (
  input  logic            upd_form,
  input  logic [REGW-1:0] ra_sel,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  input  logic [SHW-1:0]  sh_amt,
  output logic [XLEN-1:0] ea_o
);
  import sia_pkg::*;

  logic            base_is_zero;
  logic [XLEN-1:0] base;
  logic [63:0]     sum64;

  assign base_is_zero = !upd_form && (ra_sel == '0);
  assign base         = base_is_zero ? '0 : ra_val;
  assign sum64        = scaled_sum(64'(base), 64'(rb_val), int'(unsigned'(sh_amt)));
  assign ea_o         = sum64[XLEN-1:0];
endmodule

// File: rtl/sia_form_check.sv
module sia_form_check #(
  parameter int unsigned REGW = 5
) (
  input  logic                        in_valid,
  input  logic [sia_pkg::KIND_W-1:0]  ld_kind,
  input  logic                        upd_form,
  input  logic [REGW-1:0]             ra_sel,
  input  logic [REGW-1:0]             rt_sel,
  output logic                        bad_o,
  output logic                        wb_o,
  output logic [REGW-1:0]             wb_reg_o
);
  import sia_pkg::*;

  logic kind_unknown;
  logic upd_ra_zero;
  logic upd_alias;
  logic upd_illegal_kind;
  logic raw_bad;

  assign kind_unknown     = ld_kind > KIND_LAST;
  assign upd_ra_zero      = upd_form && (ra_sel == '0);
  assign upd_alias        = upd_form && (ra_sel == rt_sel) && rejects_alias(ld_kind);
  assign upd_illegal_kind = upd_form && no_update_kind(ld_kind);
  assign raw_bad          = kind_unknown || upd_ra_zero || upd_alias || upd_illegal_kind;

  assign bad_o    = in_valid && raw_bad;
  assign wb_o     = in_valid && upd_form && !raw_bad;
  assign wb_reg_o = wb_o ? ra_sel : '0;
endmodule

// File: rtl/sia_out_stage.sv
module sia_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          dat_o <= '0;
        end else begin
          vld_o <= vld_i;
          dat_o <= vld_i ? dat_i : '0;
        end
      end
    end else begin : g_pass
      assign vld_o = vld_i;
      assign dat_o = vld_i ? dat_i : '0;
    end
  endgenerate
endmodule

// File: rtl/sia_agen.sv
module sia_agen #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned REGW    = 5,
  parameter int unsigned SHW     = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [sia_pkg::KIND_W-1:0] ld_kind,
  input  logic                       upd_form,
  input  logic [REGW-1:0]            ra_sel,
  input  logic [REGW-1:0]            rt_sel,
  input  logic [XLEN-1:0]            ra_val,
  input  logic [XLEN-1:0]            rb_val,
  input  logic [SHW-1:0]             sh_amt,
  output logic                       out_valid,
  output logic [XLEN-1:0]            ea,
  output logic                       wb_en,
  output logic [REGW-1:0]            wb_reg,
  output logic                       bad_form
);
  localparam int unsigned PW = XLEN + REGW + 2;

  // Named internal events, visible to the bound checker.
  logic [XLEN-1:0] pre_ea;
  logic            pre_bad;
  logic            pre_wb;
  logic [REGW-1:0] pre_wb_reg;
  logic [PW-1:0]   pay_in;
  logic [PW-1:0]   pay_out;

  sia_ea_calc #(.XLEN(XLEN), .REGW(REGW), .SHW(SHW)) ea_i (
    .upd_form (upd_form),
    .ra_sel   (ra_sel),
    .ra_val   (ra_val),
    .rb_val   (rb_val),
    .sh_amt   (sh_amt),
    .ea_o     (pre_ea)
  );

  sia_form_check #(.REGW(REGW)) form_i (
    .in_valid (in_valid),
    .ld_kind  (ld_kind),
    .upd_form (upd_form),
    .ra_sel   (ra_sel),
    .rt_sel   (rt_sel),
    .bad_o    (pre_bad),
    .wb_o     (pre_wb),
    .wb_reg_o (pre_wb_reg)
  );

  assign pay_in = {pre_ea, pre_wb, pre_wb_reg, pre_bad};

  sia_out_stage #(.W(PW), .REG_OUT(REG_OUT)) stage_i (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .dat_i (pay_in),
    .vld_o (out_valid),
    .dat_o (pay_out)
  );

  assign {ea, wb_en, wb_reg, bad_form} = pay_out;
endmodule

// File: rtl/sia_agen_chk.sv
module sia_agen_chk #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned REGW    = 5,
  parameter bit          REG_OUT = 1'b1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [sia_pkg::KIND_W-1:0] ld_kind,
  input logic                       upd_form,
  input logic [REGW-1:0]            ra_sel,
  input logic [XLEN-1:0]            pre_ea,
  input logic                       pre_bad,
  input logic                       pre_wb,
  input logic                       out_valid,
  input logic [XLEN-1:0]            ea,
  input logic                       wb_en,
  input logic [REGW-1:0]            wb_reg,
  input logic                       bad_form
);
  AST_WB_NOT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !bad_form); // R8

  AST_WB_REG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_reg != '0)); // R4

  AST_WB_REG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_en |-> (wb_reg == '0)); // R8

  AST_NOUPD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !upd_form) |-> !pre_wb); // R8

  AST_UPD_RA0_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upd_form && (ra_sel == '0)) |-> pre_bad); // R4

  AST_SWAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (ld_kind >= 4'd6)) |-> !pre_wb); // R7

  AST_ZERO_BASE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !upd_form && (ra_sel == '0)) |-> (pre_ea[0] == 1'b0)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wb_en && !bad_form)); // R10

  generate
    if (REG_OUT) begin : g_stage
      AST_STAGE_EA: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ea == $past(pre_ea))); // R9
      AST_STAGE_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> out_valid); // R9
    end
  endgenerate
endmodule

bind sia_agen sia_agen_chk #(.XLEN(XLEN), .REGW(REGW), .REG_OUT(REG_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .ld_kind   (ld_kind),
  .upd_form  (upd_form),
  .ra_sel    (ra_sel),
  .pre_ea    (pre_ea),
  .pre_bad   (pre_bad),
  .pre_wb    (pre_wb),
  .out_valid (out_valid),
  .ea        (ea),
  .wb_en     (wb_en),
  .wb_reg    (wb_reg),
  .bad_form  (bad_form)
);

// File: tb/sia_agen_tb.sv
module sia_agen_tb_top;
  localparam int XLEN = 64;
  localparam int REGW = 5;

  typedef struct {
    logic [63:0] ea;
    logic        wb;
    logic [4:0]  wreg;
    logic        bad;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  ld_kind = '0;
  logic        upd_form = 1'b0;
  logic [4:0]  ra_sel = '0;
  logic [4:0]  rt_sel = '0;
  logic [63:0] ra_val = '0;
  logic [63:0] rb_val = '0;
  logic [1:0]  sh_amt = '0;
  logic        out_valid;
  logic [63:0] ea;
  logic        wb_en;
  logic [4:0]  wb_reg;
  logic        bad_form;

  int   n_vec = 0;
  int   n_bad = 0;
  exp_t sb_q[$];

  always #4 clk = ~clk; // 125 MHz

  sia_agen #(.XLEN(XLEN), .REGW(REGW), .SHW(2), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_kind(ld_kind),
    .upd_form(upd_form), .ra_sel(ra_sel), .rt_sel(rt_sel), .ra_val(ra_val),
    .rb_val(rb_val), .sh_amt(sh_amt), .out_valid(out_valid), .ea(ea),
    .wb_en(wb_en), .wb_reg(wb_reg), .bad_form(bad_form)
  );

  // Reference model from the requirements: multiplication by the scale.
  function automatic exp_t model(input logic [3:0] k, input logic u,
                                 input logic [4:0] ra, input logic [4:0] rt,
                                 input logic [63:0] av, input logic [63:0] bv,
                                 input logic [1:0] s, input string tag);
    exp_t e;
    logic [63:0] scale;
    logic [63:0] b;
    logic illegal;
    scale = 64'd2;
    for (int i = 0; i < int'(s); i++) scale = scale * 64'd2;
    b = (u == 1'b0 && ra == 5'd0) ? 64'd0 : av;
    e.ea = b + bv * scale;
    illegal = (k > 4'd8);
    if (u) begin
      if (ra == 5'd0) illegal = 1'b1;
      if (k == 4'd6 || k == 4'd7 || k == 4'd8) illegal = 1'b1;
      if ((k >= 4'd2 && k <= 4'd5) && ra == rt) illegal = 1'b1;
    end
    e.bad  = illegal;
    e.wb   = u && !illegal;
    e.wreg = e.wb ? ra : 5'd0;
    e.tag  = tag;
    return e;
  endfunction

  task automatic apply(input logic [3:0] k, input logic u, input logic [4:0] ra,
                       input logic [4:0] rt, input logic [63:0] av,
                       input logic [63:0] bv, input logic [1:0] s, input string tag);
    @(negedge clk);
    in_valid = 1'b1; ld_kind = k; upd_form = u; ra_sel = ra; rt_sel = rt;
    ra_val = av; rb_val = bv; sh_amt = s;
    sb_q.push_back(model(k, u, ra, rt, av, bv, s, tag));
  endtask

  // Monitor: compares each produced result against the oldest expectation.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected result R9 actual ea=%h expected none", ea);
      end else begin
        e = sb_q.pop_front();
        if (ea !== e.ea || wb_en !== e.wb || wb_reg !== e.wreg || bad_form !== e.bad) begin
          n_bad++;
          $display("FAIL %s actual ea=%h wb=%b reg=%0d bad=%b expected ea=%h wb=%b reg=%0d bad=%b",
                   e.tag, ea, wb_en, wb_reg, bad_form, e.ea, e.wb, e.wreg, e.bad);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R9: reset state
    n_vec++;
    if (out_valid !== 1'b0 || ea !== '0 || wb_en !== 1'b0 || bad_form !== 1'b0 || wb_reg !== '0) begin
      n_bad++;
      $display("FAIL R9 reset actual v=%b ea=%h wb=%b bad=%b expected all zero", out_valid, ea, wb_en, bad_form);
    end
    rst_n = 1'b1;

    // R1: all four scales, plain values
    for (int s = 0; s < 4; s++) begin
      apply(4'd3, 1'b0, 5'd7, 5'd3, 64'h0000_1000_0000_0000, 64'h0000_0000_0000_0123, 2'(s), "R1 scale");
      apply(4'd5, 1'b0, 5'd1, 5'd2, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 2'(s), "R1 mixed");
    end
    // R1: wraparound, index high bits shifted out, carry out of bit 63
    apply(4'd0, 1'b0, 5'd4, 5'd5, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0010, 2'd0, "R1 wrap carry");
    apply(4'd1, 1'b0, 5'd4, 5'd5, 64'h0000_0000_0000_0001, 64'hF000_0000_0000_0003, 2'd3, "R1 wrap shift-out");
    apply(4'd5, 1'b0, 5'd9, 5'd5, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 2'd0, "R1 wrap to zero");
    // R2: RA field zero in non-update form ignores ra_val
    for (int s = 0; s < 4; s++)
      apply(4'd2, 1'b0, 5'd0, 5'd6, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0000_0000_0000_0A5A, 2'(s), "R2 zero base");
    apply(4'd8, 1'b0, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 2'd1, "R2 zero base swap");
    // R3: legal update forms write back EA to RA
    apply(4'd5, 1'b1, 5'd12, 5'd13, 64'h0000_0000_0004_0000, 64'h40, 2'd2, "R3 update dbl");
    apply(4'd3, 1'b1, 5'd31, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd0, "R3 update wrap");
    // Every kind against the update rules
    for (int k = 0; k < 16; k++) begin
      apply(4'(k), 1'b1, 5'd0, 5'd4, 64'h100, 64'h8, 2'd1, "R4 update ra zero");
      apply(4'(k), 1'b1, 5'd9, 5'd9, 64'h200, 64'h3, 2'd2,
            (k <= 1) ? "R6 alias legal" : (k <= 5) ? "R5 alias illegal" : "R7 no update kind");
      apply(4'(k), 1'b1, 5'd10, 5'd11, 64'h300, 64'h5, 2'd3, (k >= 6) ? "R7 swap/unknown update" : "R3 update");
      apply(4'(k), 1'b0, 5'd10, 5'd10, 64'h400, 64'h6, 2'd0, (k >= 9) ? "R7 unknown kind" : "R8 non-update");
    end
    // R10: idle cycle after an input that would be illegal
    @(negedge clk);
    in_valid = 1'b0; ld_kind = 4'd15; upd_form = 1'b1; ra_sel = 5'd0;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0 || bad_form !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 idle actual v=%b wb=%b bad=%b expected 0 0 0", out_valid, wb_en, bad_form);
    end
    apply(4'd1, 1'b1, 5'd3, 5'd3, 64'h10, 64'h10, 2'd0, "R6 after idle");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9 missing results actual %0d pending expected 0", sb_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule